// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a high-rate clock by a programmable ratio N = P·B + A and emits one single-cycle pulse per N input cycles, for a phase detector that compares it with a divided reference. Dividing this way lets a loop's output frequency follow f_out = (P·B + A)·f_ref / R, with R set by a separate reference divider. The dual-modulus prescaler is modelled digitally as a counter that divides by P or by P+1. The modulus-control output selects P+1 while the swallow count A is still non-zero and P after it reaches zero. The main count B ends the output cycle.

The prescaler size is picked by one select bit from two parameterised values, 8 and 16 by default. The A and B presets, together with that select, are captured at each cycle boundary or while the counter reset is held. A preset set that breaks the range rules is flagged and left out, and the divider keeps the last legal set. The counter reset puts every counter back to the start of a cycle, so the first output pulse after release lines up with the restart. Powerdown freezes the divider where it is.

Top module: `pswallow_div`

## Requirements
- R1: While running, `div_pulse` is high for exactly one clock once every P·B + A clock cycles, where A and B are the captured presets and P is the captured prescaler size.
- R2: The captured select value 0 gives P = P_SMALL (8 by default) and 1 gives P = P_LARGE (16 by default).
- R3: Within each output cycle, `mod_hi` is high for the first A·(P+1) clock cycles and low for the remaining (B−A)·P cycles. With A = 0 it stays low for the whole cycle.
- R4: `cfg_err` is high, combinationally, exactly when `b_set` < 3 or `a_set` > `b_set`. Such a preset set is never captured, and the previously captured set stays in use.
- R5: Presets that change while the divider runs, with no counter reset, take effect only at the next output pulse. The cycle in progress keeps its length.
- R6: An edge with `cnt_rst` high puts the divider at the start of a cycle and captures the legal presets. The first `div_pulse` follows N running edges after release.
- R7: While `pwdn` is high and `cnt_rst` is low, the divider holds its state and `div_pulse` stays low. Counting resumes from the held position when `pwdn` falls. `cnt_rst` takes priority over `pwdn`.
- R8: After asynchronous reset, `div_pulse` and `mod_hi` are low, and the captured presets are A = 0, B = 3 with the small prescaler, giving a period of 3·P_SMALL.
- R9: The corner settings A = B (every prescaler period at P+1) and A = 0 with B = 3 (the shortest ratio) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Prescaler size select: 0 small, 1 large |
| a_set | input | A_W (4) | Swallow count preset A |
| b_set | input | B_W (11) | Main count preset B |
| cnt_rst | input | 1 | Synchronous counter reset, restarts the cycle |
| pwdn | input | 1 | Powerdown: freezes the divider |
| div_pulse | output | 1 | One-cycle pulse per divided period |
| mod_hi | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| cfg_err | output | 1 | Presented preset set breaks the range rules |

## Verification
A wrong count in the swallow or main counter shows at once on `mod_hi`: it falls at the wrong cycle inside the period. Within that same period `div_pulse` then lands early or late. A prescaler that wraps at the wrong modulus moves both outputs by one cycle per prescaler period, so the error appears within the first P+1 cycles of a run. A faulty capture or range check shows as a wrong period on the first pulse after the next boundary.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Modulus chosen by the dual-modulus stage
  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } psd_mod_e;

  // Smallest main-count preset allowed
  localparam int unsigned PSD_B_MIN = 3;

endpackage

// File: rtl/psd_cfg_latch.sv
module psd_cfg_latch
  import psd_pkg::*;
#(
  parameter int unsigned A_W = 4,
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           psel_in,
  output logic [A_W-1:0] a_nxt,
  output logic [B_W-1:0] b_nxt,
  output logic           psel_nxt,
  output logic           psel_q,
  output logic           bad_cfg
);

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic [B_W-1:0] a_ext;
  logic           legal;

  always_comb begin
    a_ext = B_W'(a_in);
    legal = (b_in >= B_W'(PSD_B_MIN)) && (a_ext <= b_in);
    bad_cfg = !legal;
    a_nxt    = legal ? a_in    : a_q;
    b_nxt    = legal ? b_in    : b_q;
    psel_nxt = legal ? psel_in : psel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= B_W'(PSD_B_MIN);
      psel_q <= 1'b0;
    end else if (ld) begin
      a_q    <= a_nxt;
      b_q    <= b_nxt;
      psel_q <= psel_nxt;
    end
  end

  // R4: the captured set always obeys the range rules
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q >= B_W'(PSD_B_MIN)) && (B_W'(a_q) <= b_q));

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned P_SMALL = 8,
  parameter int unsigned P_LARGE = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     adv,
  input  logic     big_sel,
  input  psd_mod_e modc,
  output logic     period_end
);

  localparam int unsigned P_MAX = (P_LARGE > P_SMALL) ? P_LARGE : P_SMALL;
  localparam int unsigned PC_W  = $clog2(P_MAX + 1);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] last;

  always_comb begin
    base       = big_sel ? PC_W'(P_LARGE) : PC_W'(P_SMALL);
    last       = (modc == MOD_PLUS) ? base : base - PC_W'(1);
    period_end = (pc_q == last);
    pc_d       = pc_q;
    if (clr) begin
      pc_d = '0;
    end else if (adv) begin
      pc_d = period_end ? '0 : pc_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  // R2: the prescaler phase never passes the largest modulus
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(P_MAX));

endmodule

// File: rtl/psd_downcnt.sv
module psd_downcnt #(
  parameter int unsigned W     = 11,
  parameter int unsigned RST_V = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (ld) begin
      cnt_d = ld_val;
    end else if (dec) begin
      cnt_d = cnt - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= W'(RST_V);
    end else begin
      cnt <= cnt_d;
    end
  end

  // R3: a count is never decremented through zero
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !ld) |-> (cnt != '0));

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = 4,
  parameter int unsigned B_W     = 11,
  parameter int unsigned P_SMALL = 8,
  parameter int unsigned P_LARGE = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic [A_W-1:0] a_set,
  input  logic [B_W-1:0] b_set,
  input  logic           cnt_rst,
  input  logic           pwdn,
  output logic           div_pulse,
  output logic           mod_hi,
  output logic           cfg_err
);

  logic [A_W-1:0] a_nxt;
  logic [B_W-1:0] b_nxt;
  logic           psel_nxt;
  logic           psel_q;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic           pe;
  logic           run;
  logic           term;
  logic           load;
  logic           a_dec;
  logic           b_dec;
  logic           pulse_d;
  logic           pulse_q;
  psd_mod_e       modc;

  always_comb begin
    run     = !cnt_rst && !pwdn;
    modc    = (a_cnt != '0) ? MOD_PLUS : MOD_BASE;
    term    = pe && (b_cnt == B_W'(1));
    load    = cnt_rst || (run && term);
    b_dec   = run && pe && !term;
    a_dec   = b_dec && (modc == MOD_PLUS);
    pulse_d = run && term;
  end

  psd_cfg_latch #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (load),
    .a_in     (a_set),
    .b_in     (b_set),
    .psel_in  (psel),
    .a_nxt    (a_nxt),
    .b_nxt    (b_nxt),
    .psel_nxt (psel_nxt),
    .psel_q   (psel_q),
    .bad_cfg  (cfg_err)
  );

  psd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (load),
    .adv        (run),
    .big_sel    (psel_q),
    .modc       (modc),
    .period_end (pe)
  );

  psd_downcnt #(.W(A_W), .RST_V(0)) u_acnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (load),
    .ld_val (a_nxt),
    .dec    (a_dec),
    .cnt    (a_cnt)
  );

  psd_downcnt #(.W(B_W), .RST_V(PSD_B_MIN)) u_bcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (load),
    .ld_val (b_nxt),
    .dec    (b_dec),
    .cnt    (b_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign div_pulse = pulse_q;
  assign mod_hi    = (modc == MOD_PLUS);

  // R1: the output pulse is one clock wide
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R7: no pulse follows a frozen edge
  pwdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwdn) && !$past(cnt_rst)) |-> !div_pulse);

  // R3: modulus control drops only at a prescaler period end or a reload
  mod_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(pe || load));

  // R6: a counter reset leaves the divider at the start of a cycle
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !div_pulse);

endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PS = 8;
  localparam int PL = 16;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk;
  logic        rst_n;
  logic        psel;
  logic [3:0]  a_set;
  logic [10:0] b_set;
  logic        cnt_rst;
  logic        pwdn;
  logic        div_pulse;
  logic        mod_hi;
  logic        cfg_err;

  int errors = 0;
  int checks = 0;
  string cur_req = "R8";
  bit done = 0;

  // behavioural model state
  int m_a = 0;
  int m_b = 3;
  int m_ps = 0;
  int m_cnt = 0;
  bit m_pulse = 0;
  int pulse_n = 0;

  pswallow_div u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .a_set     (a_set),
    .b_set     (b_set),
    .cnt_rst   (cnt_rst),
    .pwdn      (pwdn),
    .div_pulse (div_pulse),
    .mod_hi    (mod_hi),
    .cfg_err   (cfg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit legal_in();
    return (int'(b_set) >= 3) && (int'(a_set) <= int'(b_set));
  endfunction

  function automatic int pval(int s);
    return (s != 0) ? PL : PS;
  endfunction

  task automatic capture();
    if (legal_in()) begin
      m_a = int'(a_set);
      m_b = int'(b_set);
      m_ps = int'(psel);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 3; m_ps = 0; m_cnt = 0; m_pulse = 0;
    end else if (cnt_rst) begin
      m_cnt = 0; m_pulse = 0;
      capture();
    end else if (pwdn) begin
      m_pulse = 0;
    end else if (m_cnt + 1 == pval(m_ps) * m_b + m_a) begin
      m_pulse = 1; m_cnt = 0;
      capture();
    end else begin
      m_pulse = 0; m_cnt = m_cnt + 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "div_pulse", int'(div_pulse), int'(m_pulse));
      check("R3", "mod_hi", int'(mod_hi), int'(m_cnt < m_a * (pval(m_ps) + 1)));
      check("R4", "cfg_err", int'(cfg_err), int'(!legal_in()));
      if (div_pulse) pulse_n++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic restart(int a, int b, bit ps);
    a_set = 4'(a); b_set = 11'(b); psel = ps; cnt_rst = 1'b1;
    step(2);
    cnt_rst = 1'b0;
  endtask

  initial begin
    psel = 1'b0; a_set = '0; b_set = 11'd3; cnt_rst = 1'b0; pwdn = 1'b0;
    rst_n = 1'b0;
    step(3);
    // R8: outputs low in reset, default period 3*P_SMALL
    check("R8", "div_pulse in reset", int'(div_pulse), 0);
    check("R8", "mod_hi in reset", int'(mod_hi), 0);
    rst_n = 1'b1;
    cur_req = "R8";
    step(80);

    // R1 / R6: restart and run at several ratios
    cur_req = "R6";
    restart(5, 9, 1'b0);
    cur_req = "R1";
    step(200);
    // R2: large prescaler
    cur_req = "R2";
    restart(3, 20, 1'b1);
    step(700);

    // R1: randomised legal settings
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      int b, a, amax;
      b = 3 + int'($urandom % 30);
      amax = (b < 15) ? b : 15;
      a = int'($urandom % (amax + 1));
      restart(a, b, 1'($urandom % 2));
      step(2 * (pval(int'(psel)) * b + a) + 5);
    end

    // R5: change presets mid-run with no restart
    cur_req = "R5";
    restart(2, 6, 1'b0);
    step(20);
    a_set = 4'd7; b_set = 11'd10; psel = 1'b1;
    step(400);

    // R4: illegal sets are ignored, old set kept
    cur_req = "R4";
    restart(1, 5, 1'b0);
    b_set = 11'd2; a_set = 4'd0;
    step(120);
    a_set = 4'd10; b_set = 11'd7;
    step(120);
    restart(12, 4, 1'b1);
    step(120);

    // R7: powerdown freezes then resumes
    cur_req = "R7";
    restart(4, 8, 1'b0);
    step(30);
    pwdn = 1'b1;
    step(50);
    pwdn = 1'b0;
    step(200);
    pwdn = 1'b1; cnt_rst = 1'b1;
    step(3);
    cnt_rst = 1'b0;
    step(10);
    pwdn = 1'b0;
    step(150);

    // R9: corner ratios
    cur_req = "R9";
    restart(15, 15, 1'b1);
    step(600);
    restart(0, 3, 1'b0);
    step(100);

    done = 1;
    check("R1", "pulses seen", int'(pulse_n > 20), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule